// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block sits between a register interface and a byte-level I2C bus engine. It decodes the control register and runs each master transfer from the command bits. Writing the control register with the start bit set begins a transfer. The block issues an addressed start to the engine, loads the byte count, and moves data bytes one at a time. It then either ends the transfer with a bus stop or hands control back with an access-ready indication. The start and stop command bits clear themselves as the sequence moves on.

Bytes to send are written one at a time into a small packing buffer, which holds up to three bytes and hands them out oldest first. Each received byte is kept in a holding register until software reads it. The block does not keep interrupt status itself: it sends single-cycle set and clear pulses to a separate status and interrupt unit. A revision parameter selects how a controller reset is requested. On an older revision, clearing the enable bit resets the block. On a newer revision, a reset comes from the system-control register, and the system-status register reads back the enable bit.

Top module: `i2cs_seq`

## Requirements
- R1: After reset, the control (0x24), count (0x18) and system-status (0x10) registers read 0, and no engine request is active.
- R2: A write to the control register stores only the bits of mask 0xCF87. Bit 15 is enable, bit 10 is master, bit 9 selects transmit (1) or receive (0), bit 8 is extended addressing, bit 1 is stop and bit 0 is start.
- R3: A start bit written while enable is 0, master is 0 or extended addressing is 1 causes no engine request, and the stored value keeps its start bit.
- R4: An accepted start raises exactly one engine request at a time: a start with the 7-bit slave address from offset 0x2C and read = NOT bit 9. The start bit clears when the engine completes the start.
- R5: If the address is not acknowledged, a NACK set pulse is raised, the stop bit clears, and no data byte is moved.
- R6: If the address is acknowledged, the current count is loaded from offset 0x18. Each byte sent or received decrements it by one, and transmit bytes leave the buffer oldest first.
- R7: When the count reaches zero with stop set, the engine performs a stop, the stop bit clears, the count is reloaded and the transmit buffer is emptied.
- R8: When the count reaches zero with stop clear, an ARDY set pulse is raised, the master bit clears, and no stop is issued.
- R9: Data writes (offset 0x1C, low byte) fill a 3-byte buffer. Each accepted write gives an XUDF clear pulse. The write that makes 3 bytes held gives an XRDY clear pulse. A write while 3 bytes are held is dropped, with no pulse.
- R10: Each received byte gives an RRDY set pulse and reads back at 0x1C. Reading it gives an RRDY clear pulse, plus an ARDY set pulse if the block is then master (bit 10 = 1) and receiver (bit 9 = 0).
- R11: A sent byte that is not acknowledged gives a NACK set pulse and halts the transfer; no further byte is sent.
- R12: On the newer revision, writing bit 1 of offset 0x20 resets the controller, 0x10 reads the enable bit, and clearing enable does not reset. On the older revision, a control write with enable 0 resets the controller, 0x10 reads 0, and offset 0x20 has no effect.
- R13: A control write with the start bit arriving while a transfer is in progress starts nothing; it is stored with the start bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 16 | Register write data (low byte for 0x1C) |
| rd_en | input | 1 | Read strobe; a read of 0x1C consumes the received byte |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 16 | Register read data (combinational) |
| eng_start_req | output | 1 | Request an addressed start |
| eng_start_addr | output | 7 | Slave address for the start |
| eng_start_read | output | 1 | Direction of the start, 1 = read |
| eng_start_done | input | 1 | Start completed (one cycle) |
| eng_start_ack | input | 1 | Address acknowledged, valid with done |
| eng_tx_req | output | 1 | Request to send one byte |
| eng_tx_byte | output | 8 | Byte to send |
| eng_tx_done | input | 1 | Send completed (one cycle) |
| eng_tx_ack | input | 1 | Byte acknowledged, valid with done |
| eng_rx_req | output | 1 | Request to receive one byte |
| eng_rx_done | input | 1 | Receive completed (one cycle) |
| eng_rx_byte | input | 8 | Received byte, valid with done |
| eng_stop_req | output | 1 | Request a bus stop |
| eng_stop_done | input | 1 | Stop completed (one cycle) |
| sts_nack_set | output | 1 | NACK set pulse |
| sts_ardy_set | output | 1 | Access-ready set pulse |
| sts_rrdy_set | output | 1 | Receive-ready set pulse |
| sts_rrdy_clr | output | 1 | Receive-ready clear pulse |
| sts_xrdy_clr | output | 1 | Transmit-ready clear pulse |
| sts_xudf_clr | output | 1 | Transmit-underflow clear pulse |

## Verification
Two events can fall in the same cycle: a data-register write can arrive in the same cycle that the engine reports a sent byte, so the packing buffer shifts in a new byte and retires its oldest one at once. The bench waits for the send-done strobe and then drives the write so that it lands on that edge. It judges the outcome by the order of bytes that reach the engine, which must stay oldest first with nothing lost or repeated. The start command can also meet a busy sequencer. A second start-bearing control write is issued while the address phase is pending, and the engine log must show exactly one start.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int REG_W = 16;

    localparam int CB_EN  = 15;
    localparam int CB_MST = 10;
    localparam int CB_TRX = 9;
    localparam int CB_XA  = 8;
    localparam int CB_STP = 1;
    localparam int CB_STT = 0;
    localparam logic [REG_W-1:0] CTRL_WMASK = 16'hCF87;
    localparam int SYSCTL_RST_BIT = 1;

    localparam logic [7:0] A_SYSST  = 8'h10;
    localparam logic [7:0] A_BUFCFG = 8'h14;
    localparam logic [7:0] A_COUNT  = 8'h18;
    localparam logic [7:0] A_DATA   = 8'h1C;
    localparam logic [7:0] A_SYSCTL = 8'h20;
    localparam logic [7:0] A_CTRL   = 8'h24;
    localparam logic [7:0] A_SADDR  = 8'h2C;

    localparam logic [7:0] REV_NEW = 8'h34;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_RUN  = 3'd2,
        S_SEND = 3'd3,
        S_RECV = 3'd4,
        S_STOP = 3'd5
    } seq_st_e;
endpackage

// File: rtl/i2cs_txpack.sv
module i2cs_txpack #(
    parameter int DEPTH = 3,
    parameter int BW    = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [BW-1:0] push_byte,
    input  logic          pop,
    output logic [LW-1:0] level,
    output logic [BW-1:0] head,
    output logic          accepted,
    output logic          filled
);
    logic [DEPTH*BW-1:0] buf_d, buf_q;
    logic [LW-1:0]       level_d, level_q;

    always_comb begin
        accepted = push && !clr && (level_q < LW'(DEPTH));
        buf_d    = buf_q;
        level_d  = level_q;
        if (clr) begin
            buf_d   = '0;
            level_d = '0;
        end else begin
            if (accepted) begin
                buf_d = {buf_q[DEPTH*BW-BW-1:0], push_byte};
            end
            level_d = level_q + LW'(accepted) - LW'(pop);
        end
        filled = accepted && (level_d == LW'(DEPTH));
        head = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level_q == LW'(i + 1)) head = buf_q[i*BW +: BW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            level_q <= '0;
        end else begin
            buf_q   <= buf_d;
            level_q <= level_d;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/i2cs_rxhold.sv
module i2cs_rxhold #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [BW-1:0] load_byte,
    input  logic          pop,
    output logic          full,
    output logic [BW-1:0] data
);
    logic          full_d, full_q;
    logic [BW-1:0] data_d, data_q;

    always_comb begin
        full_d = full_q;
        data_d = data_q;
        if (clr) begin
            full_d = 1'b0;
            data_d = '0;
        end else if (load) begin
            full_d = 1'b1;
            data_d = load_byte;
        end else if (pop) begin
            full_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            full_q <= full_d;
            data_q <= data_d;
        end
    end

    assign full = full_q;
    assign data = data_q;
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
    import i2cs_pkg::*;
#(
    parameter logic [7:0] REV = 8'h34,
    parameter int CW    = 16,
    parameter int AW    = 7,
    parameter int BW    = 8,
    parameter int DEPTH = 3,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [15:0]   wr_data,
    input  logic          rd_en,
    input  logic [7:0]    rd_addr,
    output logic [15:0]   rd_data,
    output logic          eng_start_req,
    output logic [AW-1:0] eng_start_addr,
    output logic          eng_start_read,
    input  logic          eng_start_done,
    input  logic          eng_start_ack,
    output logic          eng_tx_req,
    output logic [BW-1:0] eng_tx_byte,
    input  logic          eng_tx_done,
    input  logic          eng_tx_ack,
    output logic          eng_rx_req,
    input  logic          eng_rx_done,
    input  logic [BW-1:0] eng_rx_byte,
    output logic          eng_stop_req,
    input  logic          eng_stop_done,
    output logic          sts_nack_set,
    output logic          sts_ardy_set,
    output logic          sts_rrdy_set,
    output logic          sts_rrdy_clr,
    output logic          sts_xrdy_clr,
    output logic          sts_xudf_clr
);
    localparam bit IS_NEW = (REV >= REV_NEW);

    typedef struct packed {
        seq_st_e          st;
        logic [REG_W-1:0] ctrl;
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    cur;
        logic [AW-1:0]    sa;
        logic [REG_W-1:0] bufcfg;
        logic             nack;
        logic             ardy;
        logic             rrdy_set;
        logic             rrdy_clr;
        logic             xrdy_clr;
        logic             xudf_clr;
    } seq_r_t;

    seq_r_t r_d, r_q;

    logic          soft_rst, tx_push, tx_pop, tx_flush, tx_acc, tx_fill;
    logic [LW-1:0] tx_level;
    logic [BW-1:0] tx_head;
    logic          rx_load, rx_pop, rx_full;
    logic [BW-1:0] rx_data;
    logic          wr_ctrl;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign tx_push = wr_en && (wr_addr == A_DATA);
    assign rx_pop  = rd_en && (rd_addr == A_DATA) && rx_full;

    generate
        if (IS_NEW) begin : g_rst_new
            assign soft_rst = wr_en && (wr_addr == A_SYSCTL) && wr_data[SYSCTL_RST_BIT];
        end else begin : g_rst_old
            assign soft_rst = wr_ctrl && !wr_data[CB_EN];
        end
    endgenerate

    i2cs_txpack #(.DEPTH(DEPTH), .BW(BW)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst || tx_flush),
        .push(tx_push), .push_byte(wr_data[BW-1:0]), .pop(tx_pop),
        .level(tx_level), .head(tx_head), .accepted(tx_acc), .filled(tx_fill)
    );

    i2cs_rxhold #(.BW(BW)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .load(rx_load), .load_byte(eng_rx_byte), .pop(rx_pop),
        .full(rx_full), .data(rx_data)
    );

    always_comb begin
        r_d          = r_q;
        r_d.nack     = 1'b0;
        r_d.ardy     = 1'b0;
        r_d.rrdy_set = 1'b0;
        r_d.rrdy_clr = 1'b0;
        r_d.xrdy_clr = tx_fill;
        r_d.xudf_clr = tx_acc;
        tx_pop       = 1'b0;
        tx_flush     = 1'b0;
        rx_load      = 1'b0;

        unique case (r_q.st)
            S_ADDR: if (eng_start_done) begin
                r_d.ctrl[CB_STT] = 1'b0;
                if (!eng_start_ack) begin
                    r_d.nack         = 1'b1;
                    r_d.ctrl[CB_STP] = 1'b0;
                    r_d.st           = S_IDLE;
                end else begin
                    r_d.cur = r_q.cnt;
                    r_d.st  = S_RUN;
                end
            end
            S_RUN: begin
                if (r_q.cur == '0) begin
                    if (r_q.ctrl[CB_STP]) begin
                        r_d.st = S_STOP;
                    end else begin
                        r_d.ardy         = 1'b1;
                        r_d.ctrl[CB_MST] = 1'b0;
                        r_d.st           = S_IDLE;
                    end
                end else if (r_q.ctrl[CB_TRX]) begin
                    if (tx_level != '0) r_d.st = S_SEND;
                end else if (!rx_full) begin
                    r_d.st = S_RECV;
                end
            end
            S_SEND: if (eng_tx_done) begin
                tx_pop  = 1'b1;
                r_d.cur = r_q.cur - CW'(1);
                if (eng_tx_ack) begin
                    r_d.st = S_RUN;
                end else begin
                    r_d.nack = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            S_RECV: if (eng_rx_done) begin
                rx_load      = 1'b1;
                r_d.rrdy_set = 1'b1;
                r_d.cur      = r_q.cur - CW'(1);
                r_d.st       = S_RUN;
            end
            S_STOP: if (eng_stop_done) begin
                r_d.ctrl[CB_STP] = 1'b0;
                r_d.cur          = r_q.cnt;
                tx_flush         = 1'b1;
                r_d.st           = S_IDLE;
            end
            default: ;
        endcase

        if (rx_pop) begin
            r_d.rrdy_clr = 1'b1;
            if (r_q.ctrl[CB_MST] && !r_q.ctrl[CB_TRX]) r_d.ardy = 1'b1;
        end

        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    r_d.ctrl = wr_data & CTRL_WMASK;
                    if (r_q.st != S_IDLE) begin
                        r_d.ctrl[CB_STT] = 1'b0;
                    end else if (wr_data[CB_EN] && wr_data[CB_MST] &&
                                 !wr_data[CB_XA] && wr_data[CB_STT]) begin
                        r_d.st = S_ADDR;
                    end
                end
                A_COUNT:  r_d.cnt    = wr_data[CW-1:0];
                A_SADDR:  r_d.sa     = wr_data[AW-1:0];
                A_BUFCFG: r_d.bufcfg = wr_data;
                default: ;
            endcase
        end

        if (soft_rst) r_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (rd_addr)
            A_SYSST:  rd_data = IS_NEW ? 16'(r_q.ctrl[CB_EN]) : 16'h0;
            A_BUFCFG: rd_data = r_q.bufcfg;
            A_COUNT:  rd_data = 16'(r_q.cnt);
            A_DATA:   rd_data = 16'(rx_data);
            A_CTRL:   rd_data = r_q.ctrl;
            A_SADDR:  rd_data = 16'(r_q.sa);
            default:  rd_data = 16'h0;
        endcase
    end

    assign eng_start_req  = (r_q.st == S_ADDR);
    assign eng_start_addr = r_q.sa;
    assign eng_start_read = !r_q.ctrl[CB_TRX];
    assign eng_tx_req     = (r_q.st == S_SEND);
    assign eng_tx_byte    = tx_head;
    assign eng_rx_req     = (r_q.st == S_RECV);
    assign eng_stop_req   = (r_q.st == S_STOP);
    assign sts_nack_set   = r_q.nack;
    assign sts_ardy_set   = r_q.ardy;
    assign sts_rrdy_set   = r_q.rrdy_set;
    assign sts_rrdy_clr   = r_q.rrdy_clr;
    assign sts_xrdy_clr   = r_q.xrdy_clr;
    assign sts_xudf_clr   = r_q.xudf_clr;
endmodule

// File: rtl/i2cs_seq_chk.sv
module i2cs_seq_chk #(
    parameter int DEPTH = 3,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [7:0]    wr_addr,
    input logic          eng_start_req,
    input logic          eng_start_done,
    input logic          eng_start_ack,
    input logic          eng_tx_req,
    input logic          eng_tx_done,
    input logic          eng_tx_ack,
    input logic          eng_rx_req,
    input logic          eng_stop_req,
    input logic          eng_stop_done,
    input logic          sts_nack_set,
    input logic          sts_ardy_set,
    input logic          sts_xudf_clr,
    input logic [15:0]   ctrl,
    input logic [LW-1:0] tx_level,
    input logic          in_run,
    input logic          cur_zero
);
    a_r4_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_start_req, eng_tx_req, eng_rx_req, eng_stop_req}));

    a_r4_stt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_req && eng_start_done && !wr_en |=> !ctrl[0]);

    a_r5_addr_nack: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_req && eng_start_done && !eng_start_ack && !wr_en
        |=> sts_nack_set && !ctrl[1] && !eng_tx_req && !eng_rx_req);

    a_r7_stop_flush: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stop_req && eng_stop_done && !wr_en |=> !ctrl[1] && (tx_level == '0));

    a_r8_ardy_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        in_run && cur_zero && !ctrl[1] && !wr_en |=> sts_ardy_set && !ctrl[10] && !eng_stop_req);

    a_r9_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == 8'h1C) && (tx_level == LW'(DEPTH)) |=> !sts_xudf_clr);

    a_r11_send_nack: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_req && eng_tx_done && !eng_tx_ack && !wr_en |=> sts_nack_set && !eng_tx_req);
endmodule

bind i2cs_seq i2cs_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .eng_start_req(eng_start_req), .eng_start_done(eng_start_done),
    .eng_start_ack(eng_start_ack), .eng_tx_req(eng_tx_req),
    .eng_tx_done(eng_tx_done), .eng_tx_ack(eng_tx_ack),
    .eng_rx_req(eng_rx_req), .eng_stop_req(eng_stop_req),
    .eng_stop_done(eng_stop_done), .sts_nack_set(sts_nack_set),
    .sts_ardy_set(sts_ardy_set), .sts_xudf_clr(sts_xudf_clr),
    .ctrl(r_q.ctrl), .tx_level(tx_level),
    .in_run(r_q.st == i2cs_pkg::S_RUN), .cur_zero(r_q.cur == '0)
);

// File: tb/sim_i2cs_seq.sv
module sim_i2cs_seq;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  wr_addr = 0, rd_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        st_req, st_read, st_done = 0, st_ack = 0;
    logic [6:0]  st_addr;
    logic        tx_req, tx_done = 0, tx_ack = 0;
    logic [7:0]  tx_byte;
    logic        rx_req, rx_done = 0;
    logic [7:0]  rx_byte = 0;
    logic        sp_req, sp_done = 0;
    logic        p_nack, p_ardy, p_rrdys, p_rrdyc, p_xrdyc, p_xudfc;

    logic        w1_en = 0;
    logic [7:0]  w1_addr = 0, r1_addr = 0;
    logic [15:0] w1_data = 0, r1_data;
    logic        o1_a, o1_b, o1_c, o1_d, o1_e, o1_f, o1_g, o1_h, o1_i, o1_j, o1_k;
    logic [6:0]  o1_addr;
    logic [7:0]  o1_byte;

    i2cs_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_start_req(st_req), .eng_start_addr(st_addr), .eng_start_read(st_read),
        .eng_start_done(st_done), .eng_start_ack(st_ack),
        .eng_tx_req(tx_req), .eng_tx_byte(tx_byte), .eng_tx_done(tx_done), .eng_tx_ack(tx_ack),
        .eng_rx_req(rx_req), .eng_rx_done(rx_done), .eng_rx_byte(rx_byte),
        .eng_stop_req(sp_req), .eng_stop_done(sp_done),
        .sts_nack_set(p_nack), .sts_ardy_set(p_ardy), .sts_rrdy_set(p_rrdys),
        .sts_rrdy_clr(p_rrdyc), .sts_xrdy_clr(p_xrdyc), .sts_xudf_clr(p_xudfc)
    );

    i2cs_seq #(.REV(8'h11)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(w1_en), .wr_addr(w1_addr), .wr_data(w1_data),
        .rd_en(1'b0), .rd_addr(r1_addr), .rd_data(r1_data),
        .eng_start_req(o1_a), .eng_start_addr(o1_addr), .eng_start_read(o1_b),
        .eng_start_done(1'b0), .eng_start_ack(1'b0),
        .eng_tx_req(o1_c), .eng_tx_byte(o1_byte), .eng_tx_done(1'b0), .eng_tx_ack(1'b0),
        .eng_rx_req(o1_d), .eng_rx_done(1'b0), .eng_rx_byte(8'h00),
        .eng_stop_req(o1_e), .eng_stop_done(1'b0),
        .sts_nack_set(o1_f), .sts_ardy_set(o1_g), .sts_rrdy_set(o1_h),
        .sts_rrdy_clr(o1_i), .sts_xrdy_clr(o1_j), .sts_xudf_clr(o1_k)
    );

    int tests = 0, fails = 0;
    int log_q[$];
    int n_nack = 0, n_ardy = 0, n_rrdys = 0, n_rrdyc = 0, n_xrdyc = 0, n_xudfc = 0;
    int lat = 0, send_idx = 0, tx_nack_at = -1;
    bit addr_ack = 1;
    logic [7:0] rx_next = 8'hC0;
    bit finished = 0;
    int cyc = 0;

    // behavioural engine: answers any request after a fixed latency, logs the operation
    always @(negedge clk) begin
        st_done = 0; tx_done = 0; rx_done = 0; sp_done = 0;
        if (st_req || tx_req || rx_req || sp_req) begin
            lat++;
            if (lat == 3) begin
                lat = 0;
                if (st_req) begin
                    st_done = 1; st_ack = addr_ack;
                    log_q.push_back(32'h1000 | (int'(st_addr) << 1) | int'(st_read));
                end else if (tx_req) begin
                    tx_done = 1; tx_ack = (send_idx != tx_nack_at); send_idx++;
                    log_q.push_back(32'h2000 | int'(tx_byte));
                end else if (rx_req) begin
                    rx_done = 1; rx_byte = rx_next; rx_next++;
                    log_q.push_back(32'h3000 | int'(rx_byte));
                end else begin
                    sp_done = 1;
                    log_q.push_back(32'h4000);
                end
            end
        end else lat = 0;
        if (p_nack)  n_nack++;
        if (p_ardy)  n_ardy++;
        if (p_rrdys) n_rrdys++;
        if (p_rrdyc) n_rrdyc++;
        if (p_xrdyc) n_xrdyc++;
        if (p_xudfc) n_xudfc++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            tests++; fails++;
            $display("FAIL watchdog (all requirements) act=%0d cycles exp=fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic wr1(input logic [7:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        w1_en = 1; w1_addr = a; w1_data = d;
        @(posedge clk); #1;
        w1_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic rd1(input logic [7:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        r1_addr = a; #1; v = r1_data;
    endtask

    task automatic pop(output logic [15:0] v);
        @(posedge clk); #1;
        rd_en = 1; rd_addr = 8'h1C; #1; v = rd_data;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic clear_obs();
        @(posedge clk); #1;
        log_q.delete();
        n_nack = 0; n_ardy = 0; n_rrdys = 0; n_rrdyc = 0; n_xrdyc = 0; n_xudfc = 0;
        send_idx = 0;
    endtask

    task automatic expect_log(input int e[$], input string tag);
        check(log_q.size() == e.size(), {tag, " engine op count"}, log_q.size(), e.size());
        for (int i = 0; i < e.size() && i < log_q.size(); i++)
            check(log_q[i] == e[i], {tag, " engine op"}, log_q[i], e[i]);
    endtask

    localparam int SA = 8'h50;
    localparam int START_W = 32'h1000 | (SA << 1);
    localparam int START_R = 32'h1000 | (SA << 1) | 1;
    localparam int STOP = 32'h4000;

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // reset state
        rd(8'h24, v); check(v == 16'h0, "R1 control after reset", v, 0);
        rd(8'h18, v); check(v == 16'h0, "R1 count after reset", v, 0);
        rd(8'h10, v); check(v == 16'h0, "R1 sys status after reset", v, 0);
        check(!(st_req || tx_req || rx_req || sp_req), "R1 no engine request", 1, 0);

        // write mask, start ignored with extended addressing
        clear_obs();
        wr(8'h24, 16'hFFFF); repeat (10) @(posedge clk);
        rd(8'h24, v); check(v == 16'hCF87, "R2 control mask", v, 16'hCF87);
        check(log_q.size() == 0, "R3 no start with ext addressing", log_q.size(), 0);
        wr(8'h24, 16'h0401); repeat (10) @(posedge clk);
        rd(8'h24, v); check(v == 16'h0401, "R3 start kept when disabled", v, 16'h0401);
        check(log_q.size() == 0, "R3 no start when disabled", log_q.size(), 0);
        wr(8'h24, 16'h8001); repeat (10) @(posedge clk);
        check(log_q.size() == 0, "R3 no start without master", log_q.size(), 0);
        wr(8'h24, 16'h0000);

        // transmit with stop; second byte written in the same cycle the first completes
        clear_obs();
        wr(8'h2C, SA); wr(8'h18, 2);
        wr(8'h1C, 16'h00A1);
        wr(8'h24, 16'h8603);
        wait (tx_done == 1'b1);
        wr_en = 1; wr_addr = 8'h1C; wr_data = 16'h00A2;
        @(posedge clk); #1; wr_en = 0;
        repeat (40) @(posedge clk);
        expect_log('{START_W, 32'h20A1, 32'h20A2, STOP}, "R6 R7 transmit with stop");
        rd(8'h24, v); check(v == 16'h8600, "R4 R7 start and stop cleared", v, 16'h8600);
        check(n_xudfc == 2, "R9 xudf clear per write", n_xudfc, 2);
        check(n_ardy == 0, "R7 no ardy with stop", n_ardy, 0);

        // buffer full, no stop: access-ready handoff
        clear_obs();
        wr(8'h1C, 16'h00B1); wr(8'h1C, 16'h00B2); wr(8'h1C, 16'h00B3); wr(8'h1C, 16'h00B4);
        check(n_xudfc == 3, "R9 write while full dropped", n_xudfc, 3);
        check(n_xrdyc == 1, "R9 xrdy clear at 3 held", n_xrdyc, 1);
        wr(8'h18, 3); wr(8'h24, 16'h8601);
        repeat (60) @(posedge clk);
        expect_log('{START_W, 32'h20B1, 32'h20B2, 32'h20B3}, "R6 R8 oldest first no stop");
        check(n_ardy == 1, "R8 ardy at count zero", n_ardy, 1);
        rd(8'h24, v); check(v == 16'h8200, "R8 master cleared", v, 16'h8200);

        // master receive with stop
        clear_obs();
        rx_next = 8'hC0;
        wr(8'h18, 2); wr(8'h24, 16'h8403);
        repeat (30) @(posedge clk);
        check(n_rrdys == 1, "R10 rrdy set on first byte", n_rrdys, 1);
        pop(v); check(v == 16'h00C0, "R10 first received byte", v, 16'hC0);
        repeat (40) @(posedge clk);
        pop(v); check(v == 16'h00C1, "R10 second received byte", v, 16'hC1);
        repeat (5) @(posedge clk);
        expect_log('{START_R, 32'h30C0, 32'h30C1, STOP}, "R10 receive sequence");
        check(n_rrdyc == 2, "R10 rrdy clears", n_rrdyc, 2);
        check(n_ardy == 2, "R10 ardy on drain as master receiver", n_ardy, 2);

        // address not acknowledged
        clear_obs();
        addr_ack = 0;
        wr(8'h1C, 16'h00D1); wr(8'h18, 2); wr(8'h24, 16'h8603);
        repeat (30) @(posedge clk);
        expect_log('{START_W}, "R5 address nack no data");
        check(n_nack == 1, "R5 nack pulse", n_nack, 1);
        rd(8'h24, v); check(v == 16'h8600, "R5 stop cleared", v, 16'h8600);

        // byte not acknowledged halts the transfer
        clear_obs();
        addr_ack = 1; tx_nack_at = 0;
        wr(8'h1C, 16'h00D2); wr(8'h24, 16'h8603);
        repeat (40) @(posedge clk);
        expect_log('{START_W, 32'h20D1}, "R11 halt after byte nack");
        check(n_nack == 1, "R11 nack pulse", n_nack, 1);
        rd(8'h24, v); check(v == 16'h8602, "R11 control after halt", v, 16'h8602);

        // newer revision reset
        rd(8'h10, v); check(v == 16'h0001, "R12 sys status shows enable", v, 1);
        wr(8'h20, 16'h0002);
        rd(8'h24, v); check(v == 16'h0, "R12 control reset", v, 0);
        rd(8'h10, v); check(v == 16'h0, "R12 sys status after reset", v, 0);
        rd(8'h18, v); check(v == 16'h0, "R12 count reset", v, 0);
        clear_obs();
        tx_nack_at = -1;
        wr(8'h2C, SA); wr(8'h18, 1); wr(8'h1C, 16'h00E1); wr(8'h24, 16'h8603);
        repeat (40) @(posedge clk);
        expect_log('{START_W, 32'h20E1, STOP}, "R12 buffer emptied by reset");

        // start while busy
        clear_obs();
        wr(8'h1C, 16'h00F1); wr(8'h18, 1); wr(8'h24, 16'h8601);
        wr(8'h24, 16'h8603);
        repeat (40) @(posedge clk);
        expect_log('{START_W, 32'h20F1, STOP}, "R13 busy start dropped");
        rd(8'h24, v); check(v == 16'h8600, "R13 control after busy start", v, 16'h8600);

        // clearing enable on newer revision keeps state
        wr(8'h18, 5); wr(8'h24, 16'h0000);
        rd(8'h18, v); check(v == 16'h0005, "R12 new rev enable clear no reset", v, 5);

        // older revision
        wr1(8'h18, 7); wr1(8'h20, 16'h0002);
        rd1(8'h18, v); check(v == 16'h0007, "R12 old rev sysctl ignored", v, 7);
        wr1(8'h24, 16'h8000);
        rd1(8'h10, v); check(v == 16'h0, "R12 old rev sys status reads 0", v, 0);
        rd1(8'h24, v); check(v == 16'h8000, "R2 old rev control stored", v, 16'h8000);
        wr1(8'h24, 16'h0000);
        rd1(8'h18, v); check(v == 16'h0, "R12 old rev enable clear resets", v, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule